// File: doc/BRIEF.md
# Per-Core Countdown Event Timer

This block is a private timer for one processor core. Software reaches it through a small indexed register port: an index, a write strobe, write data and combinational read data. No address decoding on a shared bus is involved. The block holds two independent time bases. The first is a free-running timestamp counter that starts at zero after reset and advances by one on every clock. Nothing software does can disturb it. The second is a one-shot countdown that raises the core's interrupt a programmed number of clocks after software writes the load register.

Software enables event mode once by writing 1 to the control register. From then on, each write of a delta to the load register arms the next event; no separate start command is needed. When the countdown expires, the pending flag is set and drives the interrupt output. The countdown then stays idle until the load register is written again. Software acknowledges the interrupt by writing any value to the status register.

Top module: `core_event_timer`

## Requirements
- R1: The register indices are fixed. Index 0 is control, and bit 0 reads back the enable bit. Index 1 is status, and bit 0 reads back the pending flag. Index 3 returns the timestamp counter. Index 6 returns the last value written to the load register. All other bits of control and status read as 0.
- R2: The timestamp counter reads 0 in the first cycle after reset and increases by exactly one every clock, wrapping at all-ones. Writes to any index, including index 3 and the load register, leave it unchanged.
- R3: With the block enabled, a write of N (N >= 2) to the load register makes the interrupt rise exactly N clock cycles after the cycle of the write. A write of 0 or 1 makes it rise after one cycle.
- R4: After an expiry the pending flag and the interrupt stay high until they are cleared. The countdown stays idle, and a second event does not occur until the load register is written again.
- R5: A load write while a countdown is active restarts the countdown from the new value, and the old deadline produces no event.
- R6: A write of any data to the status index clears the pending flag and drops the interrupt in the next cycle. If an expiry occurs in the same cycle as that write, the flag stays set.
- R7: Writing control with bit 0 = 0 disables the block and cancels an armed countdown. Writing 1 again does not resume the cancelled countdown. The pending flag is not affected.
- R8: A load write while the block is disabled stores the value, which reads back at index 6, but arms nothing.
- R9: Reads of indices other than 0, 1, 3 and 6 return 0, and writes to them change no register.
- R10: After reset, enable, pending, load value and timestamp are all 0 and the interrupt is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_idx | input | IDX_W (4) | Register index for reads and writes |
| reg_wr | input | 1 | Write strobe, one write per asserted cycle |
| reg_wdata | input | CNT_W (32) | Write data |
| reg_rdata | output | CNT_W (32) | Read data for reg_idx, combinational |
| irq | output | 1 | Private interrupt, high while an event is pending |

## Verification
Several properties are checked on every cycle: the timestamp advances by one per clock, unimplemented indices read as zero, a load write while enabled leaves the countdown armed, a load write while disabled leaves it unarmed, clearing control disarms, a status write drops the interrupt unless an expiry coincides, a pending interrupt holds until cleared, and the interrupt rises only out of an armed countdown at its last step. Exact event timing for a given delta can only be shown by the bench's directed scenarios, because the delay depends on data. The same holds for the absence of a second event after expiry, the restart on reload, the loss of a cancelled countdown on re-enable and the small-delta edge cases.

// File: rtl/evt_tmr_pkg.sv
package evt_tmr_pkg;

    // Register indices; software decodes these, so they are fixed.
    localparam int unsigned IDX_CTRL   = 0;
    localparam int unsigned IDX_STATUS = 1;
    localparam int unsigned IDX_TSTAMP = 3;
    localparam int unsigned IDX_LOAD   = 6;

    // Bit positions inside control and status.
    localparam int unsigned CTRL_EN_BIT  = 0;
    localparam int unsigned STAT_PND_BIT = 0;

    // Register-file state.
    typedef struct packed {
        logic        en;
        logic [63:0] load;   // upper bits unused when CNT_W < 64
    } regs_state_t;

endpackage

// File: rtl/evt_tmr_regs.sv
module evt_tmr_regs
    import evt_tmr_pkg::*;
#(
    parameter int unsigned IDX_W = 4,
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] reg_idx,
    input  logic             reg_wr,
    input  logic [CNT_W-1:0] reg_wdata,
    input  logic [CNT_W-1:0] tstamp_i,
    input  logic             pending_i,
    output logic             en_o,
    output logic             load_we_o,
    output logic [CNT_W-1:0] load_val_o,
    output logic             stat_we_o,
    output logic             disarm_o,
    output logic [CNT_W-1:0] rdata_o
);

    localparam logic [IDX_W-1:0] SEL_CTRL   = IDX_W'(IDX_CTRL);
    localparam logic [IDX_W-1:0] SEL_STATUS = IDX_W'(IDX_STATUS);
    localparam logic [IDX_W-1:0] SEL_TSTAMP = IDX_W'(IDX_TSTAMP);
    localparam logic [IDX_W-1:0] SEL_LOAD   = IDX_W'(IDX_LOAD);

    typedef struct packed {
        logic             en;
        logic [CNT_W-1:0] load;
    } state_t;

    state_t st_q, st_d;

    logic hit_ctrl, hit_status, hit_load;

    // Write decode: one strobe per implemented writable register.
    always_comb begin
        hit_ctrl   = reg_wr && (reg_idx == SEL_CTRL);
        hit_status = reg_wr && (reg_idx == SEL_STATUS);
        hit_load   = reg_wr && (reg_idx == SEL_LOAD);
    end

    // Next-state computation.
    always_comb begin
        st_d = st_q;
        if (hit_ctrl) begin
            st_d.en = reg_wdata[CTRL_EN_BIT];
        end
        if (hit_load) begin
            st_d.load = reg_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Read mux; unimplemented indices return zero.
    always_comb begin
        rdata_o = '0;
        case (reg_idx)
            SEL_CTRL:   rdata_o[CTRL_EN_BIT]  = st_q.en;
            SEL_STATUS: rdata_o[STAT_PND_BIT] = pending_i;
            SEL_TSTAMP: rdata_o               = tstamp_i;
            SEL_LOAD:   rdata_o               = st_q.load;
            default:    rdata_o               = '0;
        endcase
    end

    assign en_o       = st_q.en;
    assign load_we_o  = hit_load;
    assign load_val_o = reg_wdata;
    assign stat_we_o  = hit_status;
    assign disarm_o   = hit_ctrl && !reg_wdata[CTRL_EN_BIT];

endmodule

// File: rtl/evt_tmr_tstamp.sv
module evt_tmr_tstamp #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] count_o
);

    typedef struct packed {
        logic [CNT_W-1:0] count;
    } state_t;

    state_t st_q, st_d;

    always_comb begin
        st_d       = st_q;
        st_d.count = st_q.count + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o = st_q.count;

endmodule

// File: rtl/evt_tmr_cdown.sv
module evt_tmr_cdown #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             load_we_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             disarm_i,
    input  logic             clr_i,
    output logic             armed_o,
    output logic [CNT_W-1:0] remain_o,
    output logic             pending_o
);

    typedef struct packed {
        logic             armed;
        logic [CNT_W-1:0] remain;
        logic             pending;
    } state_t;

    state_t st_q, st_d;
    logic   fire;

    always_comb begin
        st_d = st_q;
        fire = 1'b0;
        if (load_we_i && en_i) begin
            // A new delta always wins over an expiry in the same cycle.
            st_d.armed  = 1'b1;
            st_d.remain = load_val_i;
        end else if (disarm_i) begin
            st_d.armed = 1'b0;
        end else if (st_q.armed && en_i) begin
            if (st_q.remain <= CNT_W'(1)) begin
                fire        = 1'b1;
                st_d.armed  = 1'b0;
                st_d.remain = '0;
            end else begin
                st_d.remain = st_q.remain - CNT_W'(1);
            end
        end

        // Setting beats clearing so that no event is lost.
        if (fire) begin
            st_d.pending = 1'b1;
        end else if (clr_i) begin
            st_d.pending = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign armed_o   = st_q.armed;
    assign remain_o  = st_q.remain;
    assign pending_o = st_q.pending;

endmodule

// File: rtl/core_event_timer.sv
module core_event_timer #(
    parameter int unsigned IDX_W = 4,
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] reg_idx,
    input  logic             reg_wr,
    input  logic [CNT_W-1:0] reg_wdata,
    output logic [CNT_W-1:0] reg_rdata,
    output logic             irq
);

    logic             en;
    logic             load_we;
    logic [CNT_W-1:0] load_val;
    logic             stat_we;
    logic             disarm;
    logic [CNT_W-1:0] tstamp;
    logic             armed;
    logic [CNT_W-1:0] remain;
    logic             pending;

    evt_tmr_regs #(
        .IDX_W (IDX_W),
        .CNT_W (CNT_W)
    ) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_idx    (reg_idx),
        .reg_wr     (reg_wr),
        .reg_wdata  (reg_wdata),
        .tstamp_i   (tstamp),
        .pending_i  (pending),
        .en_o       (en),
        .load_we_o  (load_we),
        .load_val_o (load_val),
        .stat_we_o  (stat_we),
        .disarm_o   (disarm),
        .rdata_o    (reg_rdata)
    );

    evt_tmr_tstamp #(
        .CNT_W (CNT_W)
    ) tstamp_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .count_o (tstamp)
    );

    evt_tmr_cdown #(
        .CNT_W (CNT_W)
    ) cdown_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (en),
        .load_we_i  (load_we),
        .load_val_i (load_val),
        .disarm_i   (disarm),
        .clr_i      (stat_we),
        .armed_o    (armed),
        .remain_o   (remain),
        .pending_o  (pending)
    );

    assign irq = pending;

endmodule

// File: rtl/evt_tmr_checker.sv
module evt_tmr_checker
    import evt_tmr_pkg::*;
#(
    parameter int unsigned IDX_W = 4,
    parameter int unsigned CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [IDX_W-1:0] reg_idx,
    input logic             reg_wr,
    input logic             wbit0,
    input logic [CNT_W-1:0] reg_rdata,
    input logic             irq,
    input logic             en,
    input logic             armed,
    input logic [CNT_W-1:0] remain,
    input logic [CNT_W-1:0] tstamp
);

    logic impl_idx, wr_load, wr_ctrl, wr_stat, last_step;

    always_comb begin
        impl_idx  = (reg_idx == IDX_W'(IDX_CTRL))   || (reg_idx == IDX_W'(IDX_STATUS)) ||
                    (reg_idx == IDX_W'(IDX_TSTAMP)) || (reg_idx == IDX_W'(IDX_LOAD));
        wr_load   = reg_wr && (reg_idx == IDX_W'(IDX_LOAD));
        wr_ctrl   = reg_wr && (reg_idx == IDX_W'(IDX_CTRL));
        wr_stat   = reg_wr && (reg_idx == IDX_W'(IDX_STATUS));
        last_step = armed && en && (remain <= CNT_W'(1));
    end

    assert_tstamp_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> tstamp == $past(tstamp) + CNT_W'(1));

    assert_unimpl_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !impl_idx |-> reg_rdata == '0);

    assert_load_arms_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_load && en) |=> armed);

    assert_load_disabled_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_load && !en) |=> !armed);

    assert_ctrl_zero_disarms_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && !wbit0) |=> (!armed && !en));

    assert_status_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && !last_step) |=> !irq);

    assert_pending_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !wr_stat) |=> irq);

    assert_irq_from_expiry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(last_step && !wr_load));

endmodule

bind core_event_timer evt_tmr_checker #(
    .IDX_W (IDX_W),
    .CNT_W (CNT_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_idx   (reg_idx),
    .reg_wr    (reg_wr),
    .wbit0     (reg_wdata[0]),
    .reg_rdata (reg_rdata),
    .irq       (irq),
    .en        (en),
    .armed     (armed),
    .remain    (remain),
    .tstamp    (tstamp)
);

// File: tb/core_event_timer_tb.sv
module core_event_timer_tb_top;

    localparam int unsigned IDX_W = 4;
    localparam int unsigned CNT_W = 32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [IDX_W-1:0] reg_idx = '0;
    logic             reg_wr = 1'b0;
    logic [CNT_W-1:0] reg_wdata = '0;
    logic [CNT_W-1:0] reg_rdata;
    logic             irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    core_event_timer #(.IDX_W(IDX_W), .CNT_W(CNT_W)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_idx   (reg_idx),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

    task automatic check(input string req, input logic [CNT_W-1:0] act,
                         input logic [CNT_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // All tasks start and end in the low phase of the clock.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic wr(input int idx, input logic [CNT_W-1:0] data);
        reg_idx   = IDX_W'(idx);
        reg_wdata = data;
        reg_wr    = 1'b1;
        tick();
        reg_wr    = 1'b0;
    endtask

    task automatic rd(input int idx, output logic [CNT_W-1:0] data);
        reg_idx = IDX_W'(idx);
        #1;
        data = reg_rdata;
    endtask

    task automatic clear_all();
        wr(1, 32'h1);
        wr(0, 32'h1);
    endtask

    task automatic t_reset();
        logic [CNT_W-1:0] v;
        check("R10 irq low", {31'b0, irq}, 32'h0);
        rd(0, v); check("R10 control", v, 32'h0);
        rd(1, v); check("R10 status", v, 32'h0);
        rd(6, v); check("R10 load", v, 32'h0);
        rd(3, v); check("R10 timestamp", v, 32'h0);
    endtask

    task automatic t_regs();
        logic [CNT_W-1:0] v;
        wr(0, 32'hFFFF_FFFF);
        rd(0, v); check("R1 control reads bit0 only", v, 32'h1);
        wr(6, 32'h1234_5678);
        rd(6, v); check("R1 load readback", v, 32'h1234_5678);
        rd(1, v); check("R1 status idle", v, 32'h0);
    endtask

    task automatic t_tstamp();
        logic [CNT_W-1:0] a, b;
        rd(3, a);
        ticks(7);
        rd(3, b); check("R2 seven cycles", b - a, 32'd7);
        rd(3, a);
        wr(3, 32'h0);
        rd(3, b); check("R2 write to index 3 ignored", b - a, 32'd1);
        rd(3, a);
        wr(6, 32'd50);
        ticks(2);
        rd(3, b); check("R2 load write no effect", b - a, 32'd3);
        wr(6, 32'd0);  // leave armed state short
        tick();
        clear_all();
    endtask

    task automatic t_delta(input int n);
        wr(6, CNT_W'(n));
        ticks(n - 1);
        check($sformatf("R3 no irq before delta %0d", n), {31'b0, irq}, 32'h0);
        tick();
        check($sformatf("R3 irq at delta %0d", n), {31'b0, irq}, 32'h1);
        clear_all();
    endtask

    task automatic t_small(input int n);
        wr(6, CNT_W'(n));
        check($sformatf("R3 delta %0d fires after one cycle", n), {31'b0, irq}, 32'h0);
        tick();
        check($sformatf("R3 delta %0d irq", n), {31'b0, irq}, 32'h1);
        clear_all();
    endtask

    task automatic t_hold_and_clear();
        logic [CNT_W-1:0] v;
        wr(6, 32'd3);
        ticks(3);
        ticks(10);
        check("R4 irq held", {31'b0, irq}, 32'h1);
        rd(1, v); check("R4 status pending", v, 32'h1);
        wr(1, 32'h0);
        check("R6 status write clears", {31'b0, irq}, 32'h0);
        ticks(20);
        check("R4 no second event", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_restart();
        wr(6, 32'd20);
        ticks(5);
        wr(6, 32'd4);
        ticks(3);
        check("R5 not before new delta", {31'b0, irq}, 32'h0);
        tick();
        check("R5 fires at new delta", {31'b0, irq}, 32'h1);
        wr(1, 32'h0);
        ticks(20);
        check("R5 old deadline silent", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_stop();
        logic [CNT_W-1:0] v;
        wr(6, 32'd6);
        ticks(2);
        wr(0, 32'h0);
        ticks(10);
        check("R7 stopped no irq", {31'b0, irq}, 32'h0);
        wr(0, 32'h1);
        ticks(10);
        check("R7 no resume", {31'b0, irq}, 32'h0);
        // pending survives a disable
        wr(6, 32'd2);
        ticks(2);
        wr(0, 32'h0);
        check("R7 pending kept on disable", {31'b0, irq}, 32'h1);
        rd(1, v); check("R7 status kept", v, 32'h1);
        wr(1, 32'h0);
        // disabled load
        wr(6, 32'd3);
        rd(6, v); check("R8 load stored while disabled", v, 32'd3);
        wr(0, 32'h1);
        ticks(10);
        check("R8 disabled load not armed", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_unimpl();
        logic [CNT_W-1:0] v;
        wr(6, 32'hA5A5_0001);
        for (int k = 0; k < 16; k++) begin
            if (k != 0 && k != 1 && k != 3 && k != 6) begin
                wr(k, 32'hFFFF_FFFF);
                rd(k, v); check($sformatf("R9 index %0d reads zero", k), v, 32'h0);
            end
        end
        rd(0, v); check("R9 control untouched", v, 32'h1);
        rd(6, v); check("R9 load untouched", v, 32'hA5A5_0001);
        check("R9 no irq", {31'b0, irq}, 32'h0);
        wr(0, 32'h0);
        wr(0, 32'h1);
    endtask

    task automatic t_max();
        logic [CNT_W-1:0] v;
        wr(6, 32'hFFFF_FFFF);
        ticks(100);
        check("R3 max delta pending later", {31'b0, irq}, 32'h0);
        rd(6, v); check("R3 max delta stored", v, 32'hFFFF_FFFF);
        wr(0, 32'h0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_tstamp();
        t_delta(2);
        t_delta(5);
        t_delta(37);
        t_small(1);
        t_small(0);
        t_hold_and_clear();
        t_restart();
        t_stop();
        t_unimpl();
        t_max();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule